// File: doc/BRIEF.md
# Synchronous Dual-Port RAM with Burst Address Counters

This block is a true dual-port static RAM with two fully independent ports, left and right. Each port has its own clock, its own two-signal select and its own registered address, control and write data. Each port can read or write any word of the shared array in any cycle, including the word the other port is using. Writes are split into two byte lanes, each with its own active-low enable. A port's read output can run in flow-through mode, where data appears in the cycle after the capture edge, or in pipelined mode, where it appears one cycle later. The choice is a static input on each port.

Each port has a burst address counter that supplies the internal address. On every rising edge of its clock the counter is cleared to zero, loaded from the external address, advanced by one, or held. The clear has the highest priority, then the load, then the advance. A port can therefore stream through consecutive words after giving a single starting address. An active-low output enable blanks the read data, and a valid flag stands in for a high-impedance bus.

The array depth is `2**ADDR_W` words of `DATA_W` bits, split into `LANES` lanes. The defaults are 512 words of 18 bits in two 9-bit lanes. Setting `ADDR_W` to 14 gives a 16K-word array with a 14-bit counter.

Top module: `dpr_burst_ram`

## Requirements
- R1: Both ports reach every word of the array, and both may access the same word in the same cycle.
- R2: A write changes only the lanes whose active-low lane enable is low. `lane_n[0]` guards data bits [8:0] and `lane_n[1]` guards bits [17:9].
- R3: A port acts only when `sel_n` is 0 and `sel` is 1 at its capture edge. Otherwise it neither writes nor produces read data, though its counter still updates.
- R4: In flow-through mode (`pipe` = 0), read data and `rvalid` = 1 are present after the capture edge and until the next edge. A write cycle gives `rvalid` = 0.
- R5: In pipelined mode (`pipe` = 1), the same read result appears one clock later than in flow-through mode.
- R6: `zero_n` = 0 sets the internal address to 0, whatever `load_n` and `step_n` are. The read or write in that same cycle uses address 0.
- R7: With `zero_n` = 1 and `load_n` = 0, the external address is captured and used as the address of that cycle.
- R8: With `zero_n` = 1 and `load_n` = 1, the address advances by one when `step_n` = 0 and holds when `step_n` = 1.
- R9: Advancing from the top address `2**ADDR_W-1` wraps to 0.
- R10: While `out_en_n` = 1, `rvalid` is 0 and `rdata` is all zeros. Whenever `rvalid` is 0, `rdata` is all zeros.
- R11: If one port writes a word while the other port reads it in the same cycle, the read returns the old contents. The new value is returned by reads from the next cycle on.
- R12: If both ports write the same word in the same cycle, the left port's data wins in every lane both ports enabled. Lanes enabled by only one port take that port's data.
- R13: After reset, both ports show `rvalid` = 0 and the internal addresses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both ports' registers |
| l_clk | input | 1 | Left port clock |
| l_sel_n | input | 1 | Left select, active low |
| l_sel | input | 1 | Left select, active high |
| l_wr_n | input | 1 | Left access kind: 0 write, 1 read |
| l_lane_n | input | LANES | Left byte-lane write enables, active low |
| l_out_en_n | input | 1 | Left read output enable, active low |
| l_load_n | input | 1 | Left counter load from l_addr, active low |
| l_step_n | input | 1 | Left counter advance, active low |
| l_zero_n | input | 1 | Left counter clear, active low, top priority |
| l_addr | input | ADDR_W | Left external address |
| l_wdata | input | DATA_W | Left write data |
| l_pipe | input | 1 | Left output mode: 0 flow-through, 1 pipelined |
| l_rdata | output | DATA_W | Left read data, zero when not valid |
| l_rvalid | output | 1 | Left read data valid |
| r_clk | input | 1 | Right port clock |
| r_sel_n | input | 1 | Right select, active low |
| r_sel | input | 1 | Right select, active high |
| r_wr_n | input | 1 | Right access kind: 0 write, 1 read |
| r_lane_n | input | LANES | Right byte-lane write enables, active low |
| r_out_en_n | input | 1 | Right read output enable, active low |
| r_load_n | input | 1 | Right counter load from r_addr, active low |
| r_step_n | input | 1 | Right counter advance, active low |
| r_zero_n | input | 1 | Right counter clear, active low, top priority |
| r_addr | input | ADDR_W | Right external address |
| r_wdata | input | DATA_W | Right write data |
| r_pipe | input | 1 | Right output mode: 0 flow-through, 1 pipelined |
| r_rdata | output | DATA_W | Right read data, zero when not valid |
| r_rvalid | output | 1 | Right read data valid |

## Verification
The bench targets the same-cycle collisions between ports. A design that committed writes too early would hand the reading port the new word instead of the old one. A design with a wrong tie-break would let the right port overwrite the left port's lanes, or would drop the lanes that only the right port enabled. It also drives the counter's priority and wrap corners: a clear given together with a load, which a design with the priority reversed would send to the external address, and an advance from the top address, which a design that saturates would leave stuck. A single-lane write followed by a write to the other lane catches a design that ignores lane enables or clears the lane it does not write. A deselected write catches a design that lets a write through without a valid select. A pipelined read checked one cycle early catches a design that applies the mode input backwards.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

   // Address counter operations, listed by rising priority
   typedef enum logic [1:0] {
      CNT_HOLD = 2'd0,
      CNT_STEP = 2'd1,
      CNT_LOAD = 2'd2,
      CNT_ZERO = 2'd3
   } cnt_op_e;

   function automatic cnt_op_e cnt_decode(input logic zero_n,
                                          input logic load_n,
                                          input logic step_n);
      if (!zero_n)      return CNT_ZERO;
      else if (!load_n) return CNT_LOAD;
      else if (!step_n) return CNT_STEP;
      return CNT_HOLD;
   endfunction

endpackage

// File: rtl/dpr_port_front.sv
module dpr_port_front
   import dpr_pkg::*;
#(
   parameter int ADDR_W = 9,
   parameter int DATA_W = 18,
   parameter int LANES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_n,
   input  logic              sel,
   input  logic              wr_n,
   input  logic [LANES-1:0]  lane_n,
   input  logic              load_n,
   input  logic              step_n,
   input  logic              zero_n,
   input  logic [ADDR_W-1:0] ext_addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [ADDR_W-1:0] q_addr,
   output logic              q_rd,
   output logic              q_wr,
   output logic [LANES-1:0]  q_lanes,
   output logic [DATA_W-1:0] q_data
);

   cnt_op_e     op;
   logic        active;
   logic [ADDR_W-1:0] nxt_addr;

   always_comb begin
      op     = cnt_decode(zero_n, load_n, step_n);
      active = !sel_n && sel;
      unique case (op)
         CNT_ZERO: nxt_addr = '0;
         CNT_LOAD: nxt_addr = ext_addr;
         CNT_STEP: nxt_addr = q_addr + 1'b1;
         default:  nxt_addr = q_addr;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_addr  <= '0;
         q_rd    <= 1'b0;
         q_wr    <= 1'b0;
         q_lanes <= '0;
         q_data  <= '0;
      end else begin
         q_addr  <= nxt_addr;
         q_rd    <= active && wr_n;
         q_wr    <= active && !wr_n;
         q_lanes <= ~lane_n;
         q_data  <= wdata;
      end
   end

endmodule

// File: rtl/dpr_mem_core.sv
module dpr_mem_core #(
   parameter int ADDR_W = 9,
   parameter int DATA_W = 18,
   parameter int LANES  = 2
) (
   input  logic              a_clk,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic              a_wr,
   input  logic [LANES-1:0]  a_lanes,
   input  logic [DATA_W-1:0] a_wdata,
   output logic [DATA_W-1:0] a_rdata,
   input  logic              b_clk,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic              b_wr,
   input  logic [LANES-1:0]  b_lanes,
   input  logic [DATA_W-1:0] b_wdata,
   output logic [DATA_W-1:0] b_rdata
);

   localparam int DEPTH  = 1 << ADDR_W;
   localparam int LANE_W = DATA_W / LANES;

   // One bank per writer; a per-lane tag pair records which bank is newer:
   // equal tags select bank A, unequal tags select bank B.
   logic [DATA_W-1:0] bank_a [DEPTH];
   logic [DATA_W-1:0] bank_b [DEPTH];
   logic [LANES-1:0]  tag_a  [DEPTH];
   logic [LANES-1:0]  tag_b  [DEPTH];
   logic [LANES-1:0]  b_yield;

   // Port A wins a same-cycle write to the same word in shared lanes
   always_comb
      b_yield = (a_wr && b_wr && (a_addr == b_addr)) ? a_lanes : '0;

   always_ff @(posedge a_clk) begin
      if (a_wr) begin
         for (int ln = 0; ln < LANES; ln++) begin
            if (a_lanes[ln]) begin
               bank_a[a_addr][ln*LANE_W +: LANE_W] <= a_wdata[ln*LANE_W +: LANE_W];
               tag_a[a_addr][ln] <= tag_b[a_addr][ln];
            end
         end
      end
   end

   always_ff @(posedge b_clk) begin
      if (b_wr) begin
         for (int ln = 0; ln < LANES; ln++) begin
            if (b_lanes[ln] && !b_yield[ln]) begin
               bank_b[b_addr][ln*LANE_W +: LANE_W] <= b_wdata[ln*LANE_W +: LANE_W];
               tag_b[b_addr][ln] <= ~tag_a[b_addr][ln];
            end
         end
      end
   end

   always_comb begin
      for (int ln = 0; ln < LANES; ln++) begin
         a_rdata[ln*LANE_W +: LANE_W] = (tag_a[a_addr][ln] == tag_b[a_addr][ln])
            ? bank_a[a_addr][ln*LANE_W +: LANE_W] : bank_b[a_addr][ln*LANE_W +: LANE_W];
         b_rdata[ln*LANE_W +: LANE_W] = (tag_a[b_addr][ln] == tag_b[b_addr][ln])
            ? bank_a[b_addr][ln*LANE_W +: LANE_W] : bank_b[b_addr][ln*LANE_W +: LANE_W];
      end
   end

endmodule

// File: rtl/dpr_out_stage.sv
module dpr_out_stage #(
   parameter int DATA_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pipe,
   input  logic              out_en_n,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] rd_word,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid
);

   logic              stg_vld;
   logic [DATA_W-1:0] stg_word;
   logic              src_vld;
   logic [DATA_W-1:0] src_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_vld  <= 1'b0;
         stg_word <= '0;
      end else begin
         stg_vld  <= rd_en;
         stg_word <= rd_word;
      end
   end

   always_comb begin
      src_vld  = pipe ? stg_vld  : rd_en;
      src_word = pipe ? stg_word : rd_word;
      rvalid   = src_vld && !out_en_n;
      rdata    = rvalid ? src_word : '0;
   end

endmodule

// File: rtl/dpr_burst_ram.sv
module dpr_burst_ram #(
   parameter int ADDR_W = 9,
   parameter int DATA_W = 18,
   parameter int LANES  = 2
) (
   input  logic              rst_n,
   input  logic              l_clk,
   input  logic              l_sel_n,
   input  logic              l_sel,
   input  logic              l_wr_n,
   input  logic [LANES-1:0]  l_lane_n,
   input  logic              l_out_en_n,
   input  logic              l_load_n,
   input  logic              l_step_n,
   input  logic              l_zero_n,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   input  logic              l_pipe,
   output logic [DATA_W-1:0] l_rdata,
   output logic              l_rvalid,
   input  logic              r_clk,
   input  logic              r_sel_n,
   input  logic              r_sel,
   input  logic              r_wr_n,
   input  logic [LANES-1:0]  r_lane_n,
   input  logic              r_out_en_n,
   input  logic              r_load_n,
   input  logic              r_step_n,
   input  logic              r_zero_n,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   input  logic              r_pipe,
   output logic [DATA_W-1:0] r_rdata,
   output logic              r_rvalid
);

   if (LANES < 1 || (DATA_W % LANES) != 0) begin : g_bad_lanes
      $error("DATA_W must split evenly into LANES");
   end
   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
      $error("ADDR_W out of supported range");
   end

   logic [ADDR_W-1:0] l_q_addr, r_q_addr;
   logic              l_q_rd, r_q_rd, l_q_wr, r_q_wr;
   logic [LANES-1:0]  l_q_lanes, r_q_lanes;
   logic [DATA_W-1:0] l_q_data, r_q_data, l_word, r_word;

   dpr_port_front #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_front_l (
      .clk(l_clk), .rst_n(rst_n), .sel_n(l_sel_n), .sel(l_sel), .wr_n(l_wr_n),
      .lane_n(l_lane_n), .load_n(l_load_n), .step_n(l_step_n), .zero_n(l_zero_n),
      .ext_addr(l_addr), .wdata(l_wdata), .q_addr(l_q_addr), .q_rd(l_q_rd),
      .q_wr(l_q_wr), .q_lanes(l_q_lanes), .q_data(l_q_data)
   );

   dpr_port_front #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_front_r (
      .clk(r_clk), .rst_n(rst_n), .sel_n(r_sel_n), .sel(r_sel), .wr_n(r_wr_n),
      .lane_n(r_lane_n), .load_n(r_load_n), .step_n(r_step_n), .zero_n(r_zero_n),
      .ext_addr(r_addr), .wdata(r_wdata), .q_addr(r_q_addr), .q_rd(r_q_rd),
      .q_wr(r_q_wr), .q_lanes(r_q_lanes), .q_data(r_q_data)
   );

   // Left is side A so it takes the same-cycle write tie
   dpr_mem_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_core (
      .a_clk(l_clk), .a_addr(l_q_addr), .a_wr(l_q_wr), .a_lanes(l_q_lanes),
      .a_wdata(l_q_data), .a_rdata(l_word),
      .b_clk(r_clk), .b_addr(r_q_addr), .b_wr(r_q_wr), .b_lanes(r_q_lanes),
      .b_wdata(r_q_data), .b_rdata(r_word)
   );

   dpr_out_stage #(.DATA_W(DATA_W)) u_out_l (
      .clk(l_clk), .rst_n(rst_n), .pipe(l_pipe), .out_en_n(l_out_en_n),
      .rd_en(l_q_rd), .rd_word(l_word), .rdata(l_rdata), .rvalid(l_rvalid)
   );

   dpr_out_stage #(.DATA_W(DATA_W)) u_out_r (
      .clk(r_clk), .rst_n(rst_n), .pipe(r_pipe), .out_en_n(r_out_en_n),
      .rd_en(r_q_rd), .rd_word(r_word), .rdata(r_rdata), .rvalid(r_rvalid)
   );

endmodule

// File: rtl/dpr_burst_ram_chk.sv
module dpr_burst_ram_chk #(
   parameter int ADDR_W = 9,
   parameter int DATA_W = 18
) (
   input logic              rst_n,
   input logic              l_clk,
   input logic              r_clk,
   input logic              l_sel_n,
   input logic              l_sel,
   input logic              l_out_en_n,
   input logic              l_load_n,
   input logic              l_step_n,
   input logic              l_zero_n,
   input logic [ADDR_W-1:0] l_addr,
   input logic              l_pipe,
   input logic [DATA_W-1:0] l_rdata,
   input logic              l_rvalid,
   input logic [ADDR_W-1:0] l_q_addr,
   input logic              r_out_en_n,
   input logic              r_load_n,
   input logic              r_zero_n,
   input logic [ADDR_W-1:0] r_addr,
   input logic [DATA_W-1:0] r_rdata,
   input logic              r_rvalid,
   input logic [ADDR_W-1:0] r_q_addr
);

   // R10
   hide_l_chk: assert property (@(posedge l_clk) disable iff (!rst_n)
      l_out_en_n |-> (!l_rvalid && l_rdata == '0));

   // R10
   hide_r_chk: assert property (@(posedge r_clk) disable iff (!rst_n)
      r_out_en_n |-> (!r_rvalid && r_rdata == '0));

   // R6
   zero_l_chk: assert property (@(posedge l_clk) disable iff (!rst_n)
      !l_zero_n |=> (l_q_addr == '0));

   // R6
   zero_r_chk: assert property (@(posedge r_clk) disable iff (!rst_n)
      !r_zero_n |=> (r_q_addr == '0));

   // R7
   load_l_chk: assert property (@(posedge l_clk) disable iff (!rst_n)
      (l_zero_n && !l_load_n) |=> (l_q_addr == $past(l_addr)));

   // R7
   load_r_chk: assert property (@(posedge r_clk) disable iff (!rst_n)
      (r_zero_n && !r_load_n) |=> (r_q_addr == $past(r_addr)));

   // R8 R9
   step_l_chk: assert property (@(posedge l_clk) disable iff (!rst_n)
      (l_zero_n && l_load_n && !l_step_n) |=> (l_q_addr == ADDR_W'($past(l_q_addr) + 1'b1)));

   // R8
   hold_l_chk: assert property (@(posedge l_clk) disable iff (!rst_n)
      (l_zero_n && l_load_n && l_step_n) |=> $stable(l_q_addr));

   // R3
   desel_l_chk: assert property (@(posedge l_clk) disable iff (!rst_n)
      (!(!l_sel_n && l_sel) && !l_pipe) |=> !l_rvalid);

endmodule

bind dpr_burst_ram dpr_burst_ram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .rst_n(rst_n), .l_clk(l_clk), .r_clk(r_clk), .l_sel_n(l_sel_n), .l_sel(l_sel),
   .l_out_en_n(l_out_en_n), .l_load_n(l_load_n), .l_step_n(l_step_n),
   .l_zero_n(l_zero_n), .l_addr(l_addr), .l_pipe(l_pipe), .l_rdata(l_rdata),
   .l_rvalid(l_rvalid), .l_q_addr(l_q_addr), .r_out_en_n(r_out_en_n),
   .r_load_n(r_load_n), .r_zero_n(r_zero_n), .r_addr(r_addr), .r_rdata(r_rdata),
   .r_rvalid(r_rvalid), .r_q_addr(r_q_addr)
);

// File: tb/dpr_burst_ram_bench.sv
module dpr_burst_ram_bench;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n;
   logic        l_sel_n, l_sel, l_wr_n, l_out_en_n, l_load_n, l_step_n, l_zero_n, l_pipe;
   logic [1:0]  l_lane_n;
   logic [8:0]  l_addr;
   logic [17:0] l_wdata, l_rdata;
   logic        l_rvalid;
   logic        r_sel_n, r_sel, r_wr_n, r_out_en_n, r_load_n, r_step_n, r_zero_n, r_pipe;
   logic [1:0]  r_lane_n;
   logic [8:0]  r_addr;
   logic [17:0] r_wdata, r_rdata;
   logic        r_rvalid;

   dpr_burst_ram u_dpr_burst_ram (
      .rst_n(rst_n),
      .l_clk(clk), .l_sel_n(l_sel_n), .l_sel(l_sel), .l_wr_n(l_wr_n), .l_lane_n(l_lane_n),
      .l_out_en_n(l_out_en_n), .l_load_n(l_load_n), .l_step_n(l_step_n), .l_zero_n(l_zero_n),
      .l_addr(l_addr), .l_wdata(l_wdata), .l_pipe(l_pipe), .l_rdata(l_rdata), .l_rvalid(l_rvalid),
      .r_clk(clk), .r_sel_n(r_sel_n), .r_sel(r_sel), .r_wr_n(r_wr_n), .r_lane_n(r_lane_n),
      .r_out_en_n(r_out_en_n), .r_load_n(r_load_n), .r_step_n(r_step_n), .r_zero_n(r_zero_n),
      .r_addr(r_addr), .r_wdata(r_wdata), .r_pipe(r_pipe), .r_rdata(r_rdata), .r_rvalid(r_rvalid)
   );

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   task automatic chk(input string tag, input logic ok, input logic [17:0] act, input logic [17:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %05h expected %05h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic l_idle();
      l_sel_n = 1'b1; l_sel = 1'b0; l_wr_n = 1'b1; l_lane_n = 2'b11; l_out_en_n = 1'b0;
      l_load_n = 1'b1; l_step_n = 1'b1; l_zero_n = 1'b1; l_addr = '0; l_wdata = '0;
   endtask

   task automatic r_idle();
      r_sel_n = 1'b1; r_sel = 1'b0; r_wr_n = 1'b1; r_lane_n = 2'b11; r_out_en_n = 1'b0;
      r_load_n = 1'b1; r_step_n = 1'b1; r_zero_n = 1'b1; r_addr = '0; r_wdata = '0;
   endtask

   // Loaded access on a port; wr selects write, lanes active low
   task automatic l_acc(input logic wr, input logic [8:0] a, input logic [1:0] ln, input logic [17:0] d);
      l_sel_n = 1'b0; l_sel = 1'b1; l_wr_n = !wr; l_lane_n = ln; l_load_n = 1'b0;
      l_step_n = 1'b1; l_zero_n = 1'b1; l_addr = a; l_wdata = d; l_out_en_n = 1'b0;
   endtask

   task automatic r_acc(input logic wr, input logic [8:0] a, input logic [1:0] ln, input logic [17:0] d);
      r_sel_n = 1'b0; r_sel = 1'b1; r_wr_n = !wr; r_lane_n = ln; r_load_n = 1'b0;
      r_step_n = 1'b1; r_zero_n = 1'b1; r_addr = a; r_wdata = d; r_out_en_n = 1'b0;
   endtask

   typedef struct packed {
      logic        sel;
      logic        zero_n;
      logic        load_n;
      logic        step_n;
      logic        wr_n;
      logic [1:0]  lane_n;
      logic        oen;
      logic [8:0]  addr;
      logic [17:0] data;
      logic        ev;
      logic [17:0] ed;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 17;
   // Left port, flow-through; each row is one cycle, checked after its capture edge (R4)
   localparam vec_t VEC [NV] = '{
      '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0, 9'd5,   18'h12345, 1'b0, 18'h00000, 4'd7},  // R7 write
      '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0, 9'd5,   18'h00000, 1'b1, 18'h12345, 4'd7},  // R7 read
      '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2'b10, 1'b0, 9'd6,   18'h3FFFF, 1'b0, 18'h00000, 4'd2},  // R2 low lane
      '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0, 9'd6,   18'h00000, 1'b1, 18'h001FF, 4'd2},
      '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2'b01, 1'b0, 9'd6,   18'h2AAAA, 1'b0, 18'h00000, 4'd2},  // R2 high lane
      '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0, 9'd6,   18'h00000, 1'b1, 18'h2ABFF, 4'd2},
      '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 9'd99,  18'h00777, 1'b0, 18'h00000, 4'd8},  // R8 step to 7
      '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0, 9'd99,  18'h00000, 1'b1, 18'h00777, 4'd8},  // R8 hold at 7
      '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0, 9'd7,   18'h11111, 1'b0, 18'h00000, 4'd3},  // R3 deselected write
      '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0, 9'd7,   18'h00000, 1'b1, 18'h00777, 4'd3},
      '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 1'b0, 9'd100, 18'h0ABCD, 1'b0, 18'h00000, 4'd6},  // R6 write at 0
      '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0, 9'd5,   18'h00000, 1'b1, 18'h0ABCD, 4'd6},  // R6 beats load
      '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0, 9'd511, 18'h3F00F, 1'b0, 18'h00000, 4'd9},  // R9 top word
      '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0, 9'd0,   18'h00000, 1'b1, 18'h3F00F, 4'd9},
      '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 2'b11, 1'b0, 9'd0,   18'h00000, 1'b1, 18'h0ABCD, 4'd9},  // R9 wrap
      '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 1'b1, 9'd5,   18'h00000, 1'b0, 18'h00000, 4'd10}, // R10 blanked
      '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 2'b11, 1'b0, 9'd0,   18'h00000, 1'b1, 18'h2ABFF, 4'd4}   // R4 step read 6
   };

   initial begin
      #(8 * 20000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      finish_run();
   end

   initial begin
      rst_n = 1'b0; l_pipe = 1'b0; r_pipe = 1'b1;
      l_idle(); r_idle();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk); #2;
      // R13 reset state
      chk("R13 left valid", !l_rvalid && l_rdata == '0, l_rdata, 18'h0);
      chk("R13 right valid", !r_rvalid && r_rdata == '0, r_rdata, 18'h0);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         l_sel_n = !VEC[i].sel; l_sel = VEC[i].sel; l_zero_n = VEC[i].zero_n;
         l_load_n = VEC[i].load_n; l_step_n = VEC[i].step_n; l_wr_n = VEC[i].wr_n;
         l_lane_n = VEC[i].lane_n; l_out_en_n = VEC[i].oen; l_addr = VEC[i].addr;
         l_wdata = VEC[i].data;
         @(posedge clk); #2;
         chk($sformatf("R%0d vector %0d", VEC[i].req, i),
             (l_rvalid == VEC[i].ev) && (l_rdata == (VEC[i].ev ? VEC[i].ed : 18'h0)),
             l_rdata, VEC[i].ev ? VEC[i].ed : 18'h0);
      end

      // R5 pipelined right port: one cycle later than flow-through; R1 reads left's word
      @(negedge clk); l_idle(); r_acc(1'b0, 9'd5, 2'b11, '0);
      @(posedge clk); #2;
      chk("R5 not yet valid", !r_rvalid, {17'h0, r_rvalid}, 18'h0);
      @(negedge clk); r_idle();
      @(posedge clk); #2;
      chk("R5 pipelined data", r_rvalid && r_rdata == 18'h12345, r_rdata, 18'h12345);

      // R11 left writes while right reads the same word
      @(negedge clk); l_acc(1'b1, 9'd20, 2'b00, 18'h00042);
      @(negedge clk); l_acc(1'b1, 9'd20, 2'b00, 18'h15555); r_acc(1'b0, 9'd20, 2'b11, '0);
      @(negedge clk); l_idle(); r_idle();
      @(posedge clk); #2;
      chk("R11 right sees old", r_rvalid && r_rdata == 18'h00042, r_rdata, 18'h00042);
      @(negedge clk); r_acc(1'b0, 9'd20, 2'b11, '0);
      @(negedge clk); r_idle();
      @(posedge clk); #2;
      chk("R11 right sees new", r_rvalid && r_rdata == 18'h15555, r_rdata, 18'h15555);

      // R11 right writes while left reads the same word (R1 same word, same cycle)
      @(negedge clk); l_acc(1'b1, 9'd21, 2'b00, 18'h00001);
      @(negedge clk); l_acc(1'b0, 9'd21, 2'b11, '0); r_acc(1'b1, 9'd21, 2'b00, 18'h2FFFF);
      @(posedge clk); #2;
      chk("R11 left sees old", l_rvalid && l_rdata == 18'h00001, l_rdata, 18'h00001);
      @(negedge clk); l_acc(1'b0, 9'd21, 2'b11, '0); r_idle();
      @(posedge clk); #2;
      chk("R11 left sees new", l_rvalid && l_rdata == 18'h2FFFF, l_rdata, 18'h2FFFF);

      // R12 both write one word, both lanes
      @(negedge clk); l_acc(1'b1, 9'd30, 2'b00, 18'h11111); r_acc(1'b1, 9'd30, 2'b00, 18'h22222);
      @(negedge clk); l_acc(1'b0, 9'd30, 2'b11, '0); r_idle();
      @(posedge clk); #2;
      chk("R12 left wins", l_rvalid && l_rdata == 18'h11111, l_rdata, 18'h11111);

      // R12 left low lane only, right both lanes: low from left, high from right
      @(negedge clk); l_acc(1'b1, 9'd31, 2'b10, 18'h00005); r_acc(1'b1, 9'd31, 2'b00, 18'h3FE07);
      @(negedge clk); l_idle(); r_acc(1'b0, 9'd31, 2'b11, '0);
      @(negedge clk); r_idle();
      @(posedge clk); #2;
      chk("R12 lane split", r_rvalid && r_rdata == 18'h3FE05, r_rdata, 18'h3FE05);

      @(negedge clk); l_idle(); r_idle();
      @(posedge clk);
      finish_run();
   end

endmodule